// File: doc/BRIEF.md
# Morphological Program Sequencer

This block steps through a program of 32-bit words held in an external program store. It has one synchronous read port with one cycle of latency. A word whose top nibble is zero is an array operation. Its low 28 bits go out on a single-cycle broadcast strobe, in program order. All other words are executed inside the block: counted loops, loops that run until a flag condition holds, subroutine calls and returns, jumps, mapping statements and an explicit block separator.

The array operations between two non-array words form an update block. When a non-array word follows at least one pending array operation, the sequencer first asks the window generator to sweep the image. It pulses a start line and waits for the generator to report completion. The generator reports three whole-image conditions for each window it visits: all-ones, all-zeros and unchanged. The sequencer ANDs each condition over every window of the sweep and keeps the result. Conditional loops test it after the sweep.

Return addresses and loop frames share one stack of 32-bit entries. Pushing onto a full stack, or popping from an empty one, stops the program and raises an error line.

Top module: `morph_seq`

## Requirements
- R1: After reset, busy, err, arr_valid, map_valid and win_start are low and pm_addr is 0. A one-cycle run pulse while idle clears err and the stack and starts fetching at address 0.
- R2: Opcode 0 (bits 31:28) raises arr_valid for one cycle with bits 27:0 on arr_word. Array operations appear in execution order, and the program counter advances by one.
- R3: Any non-array word that follows at least one array operation not yet swept first produces exactly one win_start pulse. The program counter holds until win_done, and then the word executes. A non-array word with no pending array operation produces no sweep. Opcode 1 does nothing besides this.
- R4: Flags are latched at win_done as the AND over the sweep's windows of win_flags. Bit 0 means all ones, bit 1 means all zeros and bit 2 means unchanged. Before the first sweep of a run all flags read 0.
- R5: Opcode 2 with count in bits 7:0 opens a counted loop, and opcode 3 closes it. The body runs count times, counts 0 and 1 both run it once, and loops nest.
- R6: Opcode 4 marks a loop head, and opcode 5 tests flag index bits 1:0 (index 3 reads as 0), inverted when bit 4 is set. A true test leaves the loop, and a false test jumps back to the head.
- R7: Opcode 6 pushes the return address and jumps to bits 23:0. Opcode 7 pops that address into the program counter, and opcode 8 jumps to bits 23:0 without touching the stack.
- R8: Opcode 9 raises map_valid for one cycle with bits 27:0 on map_word.
- R9: A push with STACK_DEPTH entries in use, or a pop from an empty stack, sets err and drops busy, and nothing further is broadcast. The stack pointer never exceeds STACK_DEPTH.
- R10: Opcode 15 closes any pending block with a sweep and then drops busy. Opcodes 10 to 14 are skipped.
- R11: At most one of arr_valid, map_valid and win_start is high in any cycle, and none is high while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Start pulse, accepted while idle |
| busy | output | 1 | Program in progress |
| err | output | 1 | Stack overflow or underflow stopped the last run |
| pm_addr | output | 24 | Program store read address |
| pm_rdata | input | 32 | Program word, one cycle after pm_addr |
| arr_valid | output | 1 | Array operation strobe |
| arr_word | output | 28 | Array operation payload |
| map_valid | output | 1 | Mapping statement strobe |
| map_word | output | 28 | Mapping statement payload |
| win_start | output | 1 | Sweep request pulse to window generator |
| win_flag_valid | input | 1 | One window's flags are present |
| win_flags | input | 3 | {unchanged, all zeros, all ones} for that window |
| win_done | input | 1 | Sweep finished |

## Verification
The assertions assume the window generator answers a win_start only after that pulse. They also assume it raises win_done once per request and never raises win_flag_valid or win_done outside a sweep. The bench's generator model acts only when it has seen win_start. It then drives one flag-valid cycle per window and a single done cycle. The program store holds each address stable while the sequencer waits, and run is pulsed only when busy is low.

// File: rtl/morph_seq.sv
module morph_seq #(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 32,
  parameter int SP_W        = 8,
  parameter int STACK_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  output logic              busy,
  output logic              err,
  output logic [ADDR_W-1:0] pm_addr,
  input  logic [DATA_W-1:0] pm_rdata,
  output logic              arr_valid,
  output logic [DATA_W-5:0] arr_word,
  output logic              map_valid,
  output logic [DATA_W-5:0] map_word,
  output logic              win_start,
  input  logic              win_flag_valid,
  input  logic [2:0]        win_flags,
  input  logic              win_done
);
  localparam int FLD_W = DATA_W - 4;
  localparam int CNT_W = DATA_W - ADDR_W;
  localparam int IDX_W = (STACK_DEPTH > 1) ? $clog2(STACK_DEPTH) : 1;

  localparam logic [3:0] OP_ARR = 4'h0, OP_UPD = 4'h1, OP_FOR = 4'h2, OP_ENDF = 4'h3,
                         OP_REP = 4'h4, OP_UNTL = 4'h5, OP_CALL = 4'h6, OP_RET = 4'h7,
                         OP_JMP = 4'h8, OP_MAP = 4'h9, OP_HALT = 4'hF;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_LOAD, S_EXEC, S_SWEEP} st_t;

  st_t               st;
  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] ir;
  logic [SP_W-1:0]   sp;
  logic [2:0]        flags, acc;
  logic              blk_open;
  logic [DATA_W-1:0] stk [STACK_DEPTH];

  logic              stk_we;
  logic [IDX_W-1:0]  stk_wi;
  logic [DATA_W-1:0] stk_wd;

  wire [3:0]        opc      = ir[DATA_W-1 -: 4];
  wire [SP_W-1:0]   sp_dn    = sp - SP_W'(1);
  wire [DATA_W-1:0] tos      = stk[sp_dn[IDX_W-1:0]];
  wire [ADDR_W-1:0] tos_addr = tos[ADDR_W-1:0];
  wire [CNT_W-1:0]  tos_cnt  = tos[DATA_W-1 -: CNT_W];
  wire              full     = (sp == SP_W'(STACK_DEPTH));
  wire              empty    = (sp == '0);
  wire [ADDR_W-1:0] pc_nx    = pc + ADDR_W'(1);
  wire [3:0]        flag_vec = {1'b0, flags};
  wire              test_ok  = flag_vec[ir[1:0]] ^ ir[4];
  wire              ctl_exec = (st == S_EXEC) && (opc != OP_ARR) && !blk_open;

  assign pm_addr = pc;

  always_comb begin
    stk_we = 1'b0;
    stk_wi = sp[IDX_W-1:0];
    stk_wd = '0;
    if (ctl_exec) begin
      case (opc)
        OP_FOR: begin
          stk_we = !full;
          stk_wd = {ir[CNT_W-1:0], pc_nx};
        end
        OP_REP, OP_CALL: begin
          stk_we = !full;
          stk_wd = {{CNT_W{1'b0}}, pc_nx};
        end
        OP_ENDF: begin
          stk_we = !empty && (tos_cnt > CNT_W'(1));
          stk_wi = sp_dn[IDX_W-1:0];
          stk_wd = {tos_cnt - CNT_W'(1), tos_addr};
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (stk_we) stk[stk_wi] <= stk_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_IDLE;
      pc        <= '0;
      ir        <= '0;
      sp        <= '0;
      flags     <= '0;
      acc       <= '0;
      blk_open  <= 1'b0;
      busy      <= 1'b0;
      err       <= 1'b0;
      arr_valid <= 1'b0;
      arr_word  <= '0;
      map_valid <= 1'b0;
      map_word  <= '0;
      win_start <= 1'b0;
    end else begin
      arr_valid <= 1'b0;
      map_valid <= 1'b0;
      win_start <= 1'b0;
      case (st)
        S_IDLE: if (run) begin
          pc       <= '0;
          sp       <= '0;
          flags    <= '0;
          blk_open <= 1'b0;
          err      <= 1'b0;
          busy     <= 1'b1;
          st       <= S_FETCH;
        end
        S_FETCH: st <= S_LOAD;
        S_LOAD: begin
          ir <= pm_rdata;
          st <= S_EXEC;
        end
        S_SWEEP: begin
          if (win_flag_valid) acc <= acc & win_flags;
          if (win_done) begin
            flags    <= acc & (win_flag_valid ? win_flags : 3'b111);
            blk_open <= 1'b0;
            st       <= S_EXEC;
          end
        end
        S_EXEC: begin
          if (opc == OP_ARR) begin
            arr_valid <= 1'b1;
            arr_word  <= ir[FLD_W-1:0];
            blk_open  <= 1'b1;
            pc        <= pc_nx;
            st        <= S_FETCH;
          end else if (blk_open) begin
            win_start <= 1'b1;
            acc       <= 3'b111;
            st        <= S_SWEEP;
          end else begin
            st <= S_FETCH;
            case (opc)
              OP_MAP: begin
                map_valid <= 1'b1;
                map_word  <= ir[FLD_W-1:0];
                pc        <= pc_nx;
              end
              OP_FOR, OP_REP: begin
                if (full) begin
                  err <= 1'b1; busy <= 1'b0; st <= S_IDLE;
                end else begin
                  sp <= sp + SP_W'(1);
                  pc <= pc_nx;
                end
              end
              OP_CALL: begin
                if (full) begin
                  err <= 1'b1; busy <= 1'b0; st <= S_IDLE;
                end else begin
                  sp <= sp + SP_W'(1);
                  pc <= ir[ADDR_W-1:0];
                end
              end
              OP_ENDF: begin
                if (empty) begin
                  err <= 1'b1; busy <= 1'b0; st <= S_IDLE;
                end else if (tos_cnt > CNT_W'(1)) begin
                  pc <= tos_addr;
                end else begin
                  sp <= sp_dn;
                  pc <= pc_nx;
                end
              end
              OP_UNTL: begin
                if (empty) begin
                  err <= 1'b1; busy <= 1'b0; st <= S_IDLE;
                end else if (test_ok) begin
                  sp <= sp_dn;
                  pc <= pc_nx;
                end else begin
                  pc <= tos_addr;
                end
              end
              OP_RET: begin
                if (empty) begin
                  err <= 1'b1; busy <= 1'b0; st <= S_IDLE;
                end else begin
                  sp <= sp_dn;
                  pc <= tos_addr;
                end
              end
              OP_JMP:  pc <= ir[ADDR_W-1:0];
              OP_HALT: begin
                busy <= 1'b0;
                st   <= S_IDLE;
              end
              default: pc <= pc_nx;
            endcase
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/morph_seq_chk.sv
module morph_seq_chk #(
  parameter int ADDR_W      = 24,
  parameter int SP_W        = 8,
  parameter int STACK_DEPTH = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              err,
  input logic              arr_valid,
  input logic              map_valid,
  input logic              win_start,
  input logic [ADDR_W-1:0] pm_addr,
  input logic [SP_W-1:0]   sp
);
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({arr_valid, map_valid, win_start}) <= 1); // R11
  AST_PULSE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_valid || map_valid || win_start) |-> busy); // R11
  AST_STACK_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    sp <= SP_W'(STACK_DEPTH)); // R9
  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> !busy); // R9
  AST_SWEEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    win_start |=> !win_start); // R3
  AST_SWEEP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    win_start |=> $stable(pm_addr)); // R3
  AST_ARR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(arr_valid) |-> pm_addr == ADDR_W'($past(pm_addr) + 1)); // R2
endmodule

bind morph_seq morph_seq_chk #(.ADDR_W(ADDR_W), .SP_W(SP_W), .STACK_DEPTH(STACK_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .err(err), .arr_valid(arr_valid),
  .map_valid(map_valid), .win_start(win_start), .pm_addr(pm_addr), .sp(sp)
);

// File: tb/test_morph_seq.sv
`timescale 1ns/1ps
module test_morph_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        run = 1'b0;
  logic        busy, err;
  logic [23:0] pm_addr;
  logic [31:0] pm_rdata = '0;
  logic        arr_valid, map_valid, win_start;
  logic [27:0] arr_word, map_word;
  logic        win_flag_valid = 1'b0;
  logic [2:0]  win_flags = '0;
  logic        win_done = 1'b0;

  always #2.5 clk = ~clk;

  morph_seq i_morph_seq (
    .clk(clk), .rst_n(rst_n), .run(run), .busy(busy), .err(err),
    .pm_addr(pm_addr), .pm_rdata(pm_rdata),
    .arr_valid(arr_valid), .arr_word(arr_word),
    .map_valid(map_valid), .map_word(map_word),
    .win_start(win_start), .win_flag_valid(win_flag_valid),
    .win_flags(win_flags), .win_done(win_done)
  );

  localparam int DEPTH = 16;
  logic [31:0] pmem [0:255];
  always @(posedge clk) pm_rdata <= pmem[pm_addr[7:0]];

  int checks = 0, fails = 0;
  int scr_mode = 0;
  logic [2:0] rnd_tab [0:63];
  logic [31:0] act_ev [0:1023];
  logic [31:0] exp_ev [0:1023];
  int act_n = 0, exp_n = 0, gsweep = 0;
  bit exp_err;

  function automatic int nwin(int k);
    return 1 + (k % 3);
  endfunction

  function automatic logic [2:0] scr(int k, int w);
    if (scr_mode == 1) return (k >= 3 || (w == 0 && k > 0)) ? 3'b101 : 3'b100;
    return rnd_tab[(k * 4 + w) & 63];
  endfunction

  function automatic logic [31:0] ins(logic [3:0] op, logic [27:0] f);
    return {op, f};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp, string what);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic log_act(logic [31:0] v);
    if (act_n < 1024) act_ev[act_n] = v;
    act_n++;
  endtask

  task automatic log_exp(logic [31:0] v);
    if (exp_n < 1024) exp_ev[exp_n] = v;
    exp_n++;
  endtask

  // trace monitor and window generator model
  initial begin
    forever begin
      @(negedge clk);
      if (arr_valid) log_act({4'h0, arr_word});
      if (map_valid) log_act({4'h8, map_word});
      if (win_start) begin
        log_act(32'h4000_0000 | gsweep);
        for (int w = 0; w < nwin(gsweep); w++) begin
          win_flag_valid = 1'b1;
          win_flags = scr(gsweep, w);
          @(negedge clk);
        end
        win_flag_valid = 1'b0;
        win_done = 1'b1;
        @(negedge clk);
        win_done = 1'b0;
        gsweep++;
      end
    end
  end

  // expected trace from the requirements
  task automatic ref_run();
    int pc = 0, sp = 0, k = 0, steps = 0;
    bit open = 0, fin = 0, hit;
    logic [2:0] fl = 3'b000;
    logic [31:0] st [0:DEPTH-1];
    logic [31:0] w;
    logic [3:0] op;
    exp_n = 0;
    exp_err = 0;
    while (!fin && steps < 5000) begin
      steps++;
      w = pmem[pc & 255];
      op = w[31:28];
      if (op == 4'h0) begin
        log_exp({4'h0, w[27:0]});
        open = 1;
        pc++;
      end else begin
        if (open) begin
          log_exp(32'h4000_0000 | k);
          fl = 3'b111;
          for (int i = 0; i < nwin(k); i++) fl &= scr(k, i);
          k++;
          open = 0;
        end
        case (op)
          4'h2, 4'h4, 4'h6: begin
            if (sp == DEPTH) begin exp_err = 1; fin = 1; end
            else begin
              st[sp] = {(op == 4'h2) ? w[7:0] : 8'h00, 24'(pc + 1)};
              sp++;
              pc = (op == 4'h6) ? int'(w[23:0]) : pc + 1;
            end
          end
          4'h3: begin
            if (sp == 0) begin exp_err = 1; fin = 1; end
            else if (st[sp-1][31:24] > 1) begin
              st[sp-1][31:24] = st[sp-1][31:24] - 1;
              pc = int'(st[sp-1][23:0]);
            end else begin sp--; pc++; end
          end
          4'h5: begin
            if (sp == 0) begin exp_err = 1; fin = 1; end
            else begin
              hit = (w[1:0] == 2'd3) ? 1'b0 : fl[w[1:0]];
              if (hit != w[4]) begin sp--; pc++; end
              else pc = int'(st[sp-1][23:0]);
            end
          end
          4'h7: begin
            if (sp == 0) begin exp_err = 1; fin = 1; end
            else begin sp--; pc = int'(st[sp][23:0]); end
          end
          4'h8: pc = int'(w[23:0]);
          4'h9: begin log_exp({4'h8, w[27:0]}); pc++; end
          4'hF: fin = 1;
          default: pc++;
        endcase
      end
    end
  endtask

  task automatic clr_mem();
    for (int i = 0; i < 256; i++) pmem[i] = 32'hF000_0000;
  endtask

  function automatic int count_ev(logic [31:0] v);
    int c = 0;
    for (int i = 0; i < act_n && i < 1024; i++) if (act_ev[i] == v) c++;
    return c;
  endfunction

  task automatic run_prog(string req);
    int t = 0;
    int bad = -1;
    ref_run();
    act_n = 0;
    gsweep = 0;
    @(negedge clk); run = 1'b1;
    @(negedge clk); run = 1'b0;
    while (busy && t < 20000) begin @(negedge clk); t++; end
    repeat (3) @(negedge clk);
    chk(t < 20000, req, t, 20000, "run completes");
    chk(err == exp_err, req, err, exp_err, "error flag");
    chk(act_n == exp_n, req, act_n, exp_n, "trace length");
    for (int i = 0; i < act_n && i < exp_n && i < 1024; i++)
      if (bad < 0 && act_ev[i] != exp_ev[i]) bad = i;
    chk(bad < 0, req, (bad < 0) ? 0 : act_ev[bad], (bad < 0) ? 0 : exp_ev[bad], "trace entry");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seed0;
    int pos;
    seed0 = $urandom(32'd20240611);
    for (int i = 0; i < 64; i++) rnd_tab[i] = 3'($urandom % 8);
    clr_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(!busy && !err, "R1", {busy, err}, 0, "idle status");
    chk(!arr_valid && !map_valid && !win_start, "R1", {arr_valid, map_valid, win_start}, 0, "strobes low");
    chk(pm_addr == 0, "R1", pm_addr, 0, "fetch address");

    // R5 R2 R3 nested counted loops
    clr_mem();
    pmem[0] = ins(4'h2, 28'd3); pmem[1] = ins(4'h2, 28'd2);
    pmem[2] = ins(4'h0, 28'h11); pmem[3] = ins(4'h3, 0);
    pmem[4] = ins(4'h0, 28'h22); pmem[5] = ins(4'h3, 0);
    run_prog("R5");
    chk(count_ev(32'h11) == 6, "R5", count_ev(32'h11), 6, "inner body count");
    chk(count_ev(32'h4000_0000 | 8) == 1 && count_ev(32'h4000_0000 | 9) == 0, "R3",
        count_ev(32'h4000_0008), 1, "one sweep per closed block");

    // R7 call, return, jump
    clr_mem();
    pmem[0] = ins(4'h6, 28'd5); pmem[1] = ins(4'h0, 28'h1);
    pmem[2] = ins(4'h8, 28'd4); pmem[3] = ins(4'h0, 28'hBAD);
    pmem[5] = ins(4'h0, 28'h2); pmem[6] = ins(4'h9, 28'h3); pmem[7] = ins(4'h7, 0);
    run_prog("R7");
    chk(count_ev(32'hBAD) == 0, "R7", count_ev(32'hBAD), 0, "jumped-over word");
    chk(count_ev(32'h8000_0003) == 1, "R8", count_ev(32'h8000_0003), 1, "mapping strobe");

    // R6 R4 repeat until all-ones, AND over windows
    scr_mode = 1;
    clr_mem();
    pmem[0] = ins(4'h4, 0); pmem[1] = ins(4'h0, 28'h7); pmem[2] = ins(4'h5, 28'h0);
    run_prog("R6");
    chk(count_ev(32'h7) == 4, "R4", count_ev(32'h7), 4, "iterations until all windows agree");

    // R6 inverted test and unchanged flag
    clr_mem();
    pmem[0] = ins(4'h4, 0); pmem[1] = ins(4'h0, 28'h8); pmem[2] = ins(4'h5, 28'h11);
    pmem[3] = ins(4'h4, 0); pmem[4] = ins(4'h0, 28'h9); pmem[5] = ins(4'h5, 28'h2);
    run_prog("R6");
    chk(count_ev(32'h8) == 1 && count_ev(32'h9) == 1, "R6", count_ev(32'h8), 1, "single pass loops");

    // R9 overflow through recursion
    clr_mem();
    pmem[0] = ins(4'h0, 28'h5); pmem[1] = ins(4'h6, 28'd0);
    run_prog("R9");
    chk(count_ev(32'h5) == DEPTH + 1, "R9", count_ev(32'h5), DEPTH + 1, "broadcasts before overflow");

    // R9 underflow
    clr_mem();
    pmem[0] = ins(4'h7, 0); pmem[1] = ins(4'h0, 28'h3);
    run_prog("R9");
    chk(act_n == 0, "R9", act_n, 0, "nothing after underflow");

    // R5 count zero runs once; R1 err cleared by new run
    clr_mem();
    pmem[0] = ins(4'h2, 28'd0); pmem[1] = ins(4'h0, 28'h44); pmem[2] = ins(4'h3, 0);
    run_prog("R1");
    chk(count_ev(32'h44) == 1, "R5", count_ev(32'h44), 1, "zero count body");

    // R3 R10 no sweep without array ops; skipped opcodes; halt closes block
    clr_mem();
    pmem[0] = ins(4'h9, 28'h5); pmem[1] = ins(4'h1, 0); pmem[2] = ins(4'hA, 28'h6);
    pmem[3] = ins(4'h1, 0); pmem[4] = ins(4'h0, 28'h66);
    run_prog("R10");
    chk(count_ev(32'h4000_0000) == 1 && count_ev(32'h4000_0001) == 0, "R3",
        count_ev(32'h4000_0000), 1, "sweeps only for pending array ops");

    // constrained random programs (R2 R5 R7 R8)
    scr_mode = 0;
    for (int p = 0; p < 10; p++) begin
      clr_mem();
      pmem[200] = ins(4'h0, 28'($urandom)); pmem[201] = ins(4'h7, 0);
      pos = 0;
      for (int s = 0; s < 4 + ($urandom % 4); s++) begin
        case ($urandom % 5)
          0: begin pmem[pos] = ins(4'h0, 28'($urandom)); pos++; end
          1: begin pmem[pos] = ins(4'h9, 28'($urandom)); pos++; end
          2: begin pmem[pos] = ins(4'h1, 0); pos++; end
          3: begin
            pmem[pos] = ins(4'h2, 28'($urandom % 4)); pos++;
            for (int b = 0; b < 1 + ($urandom % 3); b++) begin
              pmem[pos] = ins(4'h0, 28'($urandom)); pos++;
            end
            pmem[pos] = ins(4'h3, 0); pos++;
          end
          default: begin pmem[pos] = ins(4'h6, 28'd200); pos++; end
        endcase
      end
      run_prog("R2");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule